// File: doc/BRIEF.md
# Presettable Bi-Quinary Ripple Counter

This block is a four-bit counter made of two sections with their own count inputs. The low bit forms a divide-by-two section driven by the first count input. The upper three bits form a second section driven by the second count input. That section divides by five in the default decade variant and by eight when the `BINARY` parameter is set. Both count inputs are asynchronous levels. A free-running system clock samples them through a synchroniser, and a section advances once for each falling edge that is detected.

An active-low load input works as a level override. While it is low, all four outputs copy the data inputs, one system cycle behind, so the block also serves as a transparent four-bit latch. An active-low clear overrides both load and counting. Setting `link_qa` routes the low bit's own falling transitions into the second section, which gives plain BCD or binary counting from the first input alone. Feeding the top output back into the first count input gives bi-quinary order instead: the low bit becomes the most significant digit and forms a symmetric divide-by-ten square wave.

Top module: `biquinary_counter`

## Requirements
- R1: Each falling edge detected on `cnt1_in` inverts `q[0]`, provided load and clear are both high in that cycle.
- R2: In the decade variant, `q[3:1]` steps through 0,1,2,3,4 and then back to 0, one step per falling edge detected on the second section's clock.
- R3: In the binary variant (`BINARY`=1), `q[3:1]` steps through 0 to 7 and wraps to 0.
- R4: While `load_n` is low and `clear_n` is high, `q` equals the value `data` held before the last system clock edge. The outputs keep following `data` for as long as load stays low.
- R5: While `clear_n` is low, `q` becomes 0 on the next system clock edge, whatever load, data or the count inputs are doing.
- R6: With `load_n` and `clear_n` high and no detected falling edge, `q` keeps its value. Reset leaves `q` at 0.
- R7: With `link_qa`=1, every counted 1-to-0 change of `q[0]` advances `q[3:1]` on the following system clock edge, and `cnt2_in` is ignored. Ten `cnt1_in` pulses return the decade variant to 0. Sixteen pulses return the binary variant to 0.
- R8: With `cnt1_in` tied to `q[3]` and pulses on `cnt2_in`, the decade variant after n pulses reads `q[3:1]`=n mod 5 and `q[0]`=(n div 5) mod 2.
- R9: In the decade variant, an upper-section value outside 0 to 4 recovers through the fixed path 5 to 6, 6 to 7, and 7 to 0, one step per clock edge.
- R10: A falling edge detected in a cycle where load or clear is active is discarded. It has no effect after the override ends.
- R11: A count input is synchronised by two flops. A falling edge first changes `q` at the third system clock edge after the input falls. A rising edge never changes `q`. Pulses at a quarter of the system clock rate are all counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset of all flops |
| cnt1_in | input | 1 | Count input of the divide-by-two section; counts on its falling edge |
| cnt2_in | input | 1 | Count input of the upper section; counts on its falling edge |
| link_qa | input | 1 | 1: the upper section counts on the low bit's falls instead of `cnt2_in` |
| load_n | input | 1 | Active-low level load; the outputs follow `data` while it is low |
| clear_n | input | 1 | Active-low clear; highest priority |
| data | input | 4 | Preset and latch data |
| q | output | 4 | Counter state; `q[0]` is the divide-by-two bit |

## Verification
A count edge can be detected in the same cycle that load or clear is active, so counting and override can meet in one cycle. The bench provokes this by ending a count pulse and then asserting load for a single cycle at each of several offsets from that pulse. The detection then lands before, inside or just after the override window. A behavioural model that discards edges in override cycles judges `q` on every clock. Clear asserted together with load, while count pulses are running, is checked the same way, and clear must win.

// File: rtl/bq_pkg.sv
package bq_pkg;

  localparam int HI_W = 3;

  // Next value of the upper section: decade recovers 5->6->7->0.
  function automatic logic [HI_W-1:0] hi_next(input logic [HI_W-1:0] v,
                                              input logic binary);
    logic [HI_W-1:0] r;
    if (binary) begin
      r = v + 1'b1;
    end else begin
      case (v)
        3'd4, 3'd7: r = '0;
        default:    r = v + 1'b1;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/bq_fall_detect.sv
module bq_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  assign fall = prev_q & ~sync_q[STAGES-1];

  AST_FALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R11
endmodule

// File: rtl/bq_low_stage.sv
module bq_low_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_n,
  input  logic load_n,
  input  logic d,
  input  logic adv,
  output logic q,
  output logic fell
);
  logic counting;
  assign counting = clear_n & load_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= 1'b0;
      fell <= 1'b0;
    end else begin
      fell <= counting & adv & q;
      if (!clear_n)     q <= 1'b0;
      else if (!load_n) q <= d;
      else if (adv)     q <= ~q;
    end
  end

  AST_LOW_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && adv) |=> (q != $past(q))); // R1
  AST_FELL_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    fell |-> (!q && $past(q))); // R7
endmodule

// File: rtl/bq_high_stage.sv
module bq_high_stage
  import bq_pkg::*;
#(
  parameter bit BINARY = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_n,
  input  logic            load_n,
  input  logic [HI_W-1:0] d,
  input  logic            adv,
  output logic [HI_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (!clear_n) q <= '0;
    else if (!load_n)  q <= d;
    else if (adv)      q <= hi_next(q, BINARY);
  end

  AST_DECADE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!BINARY && clear_n && load_n && adv && q < 3'd5) |=> (q < 3'd5)); // R2
  AST_RECOVER_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && adv && q == 3'd7) |=> (q == 3'd0)); // R9
endmodule

// File: rtl/biquinary_counter.sv
module biquinary_counter
  import bq_pkg::*;
#(
  parameter bit BINARY      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt1_in,
  input  logic       cnt2_in,
  input  logic       link_qa,
  input  logic       load_n,
  input  logic       clear_n,
  input  logic [3:0] data,
  output logic [3:0] q
);
  logic            fall_a;
  logic            fall_b;
  logic            qa_fell;
  logic            adv_b;
  logic            q_lo;
  logic [HI_W-1:0] q_hi;

  bq_fall_detect #(.STAGES(SYNC_STAGES)) u_fd1 (
    .clk(clk), .rst_n(rst_n), .din(cnt1_in), .fall(fall_a));
  bq_fall_detect #(.STAGES(SYNC_STAGES)) u_fd2 (
    .clk(clk), .rst_n(rst_n), .din(cnt2_in), .fall(fall_b));

  assign adv_b = link_qa ? qa_fell : fall_b;

  bq_low_stage u_lo (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
    .d(data[0]), .adv(fall_a), .q(q_lo), .fell(qa_fell));

  bq_high_stage #(.BINARY(BINARY)) u_hi (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
    .d(data[3:1]), .adv(adv_b), .q(q_hi));

  assign q = {q_hi, q_lo};

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (q == 4'd0)); // R5
  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |=> (q == $past(data))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !fall_a && !adv_b) |=> $stable(q)); // R6
  AST_OVERRIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(clear_n && load_n) && fall_a && link_qa) |=> !qa_fell); // R10
endmodule

// File: tb/tb_biquinary_counter.sv
module tb_biquinary_counter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, c1, c2, link, bq, ld_n, clr_n;
  logic [3:0] d;
  logic [3:0] q_dec, q_bin;
  logic       cnt1_dec, cnt1_bin;
  int         checks = 0, errors = 0, cycles = 0;
  string      cur_req = "R6";
  bit         done = 1'b0;

  assign cnt1_dec = bq ? q_dec[3] : c1;
  assign cnt1_bin = bq ? q_bin[3] : c1;

  biquinary_counter #(.BINARY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cnt1_in(cnt1_dec), .cnt2_in(c2),
    .link_qa(link), .load_n(ld_n), .clear_n(clr_n), .data(d), .q(q_dec));
  biquinary_counter #(.BINARY(1'b1)) dut_bin (
    .clk(clk), .rst_n(rst_n), .cnt1_in(cnt1_bin), .cnt2_in(c2),
    .link_qa(link), .load_n(ld_n), .clear_n(clr_n), .data(d), .q(q_bin));

  // Behavioural reference: index 0 decade, 1 binary
  int mq[2], ha[2][3], hb[2][3], pend[2];

  function automatic int step_hi(int v, int m);
    if (m == 1) return (v + 1) % 8;
    return (v < 5) ? (v + 1) % 5 : (v + 1) % 8;
  endfunction

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        mq[m] = 0; pend[m] = 0;
        for (int k = 0; k < 3; k++) begin ha[m][k] = 0; hb[m][k] = 0; end
      end else begin
        int in1, fa, fb, lo, hi, npend;
        in1 = bq ? (mq[m] / 8) % 2 : int'(c1);
        fa = (ha[m][2] == 1 && ha[m][1] == 0) ? 1 : 0;
        fb = link ? pend[m] : ((hb[m][2] == 1 && hb[m][1] == 0) ? 1 : 0);
        ha[m][2] = ha[m][1]; ha[m][1] = ha[m][0]; ha[m][0] = in1;
        hb[m][2] = hb[m][1]; hb[m][1] = hb[m][0]; hb[m][0] = int'(c2);
        npend = (clr_n && ld_n && fa == 1 && mq[m] % 2 == 1) ? 1 : 0;
        if (!clr_n) mq[m] = 0;
        else if (!ld_n) mq[m] = int'(d);
        else begin
          lo = mq[m] % 2; hi = mq[m] / 2;
          if (fa == 1) lo = 1 - lo;
          if (fb == 1) hi = step_hi(hi, m);
          mq[m] = hi * 2 + lo;
        end
        pend[m] = npend;
      end
    end
  end

  task automatic chk(string req, logic [3:0] act, int exp);
    checks++;
    if (int'(act) != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk({cur_req, " dec model"}, q_dec, mq[0]);
      chk({cur_req, " bin model"}, q_bin, mq[1]);
    end
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse1(); c1 = 1'b1; idle(2); c1 = 1'b0; idle(2); endtask
  task automatic pulse2(); c2 = 1'b1; idle(2); c2 = 1'b0; idle(2); endtask
  task automatic do_clear(); clr_n = 1'b0; idle(1); clr_n = 1'b1; idle(1); endtask

  initial begin
    rst_n = 1'b0; c1 = 0; c2 = 0; link = 0; bq = 0; ld_n = 1; clr_n = 1; d = '0;
    idle(3); rst_n = 1'b1; idle(2);
    chk("R6 reset", q_dec, 0);
    chk("R6 reset", q_bin, 0);

    cur_req = "R11";
    c1 = 1'b1; idle(6);
    chk("R11 rising ignored", q_dec, 0);
    c1 = 1'b0; idle(2);
    chk("R11 not yet", q_dec, 0);
    idle(1);
    chk("R11 third edge", q_dec, 1);

    cur_req = "R1";
    do_clear();
    repeat (3) pulse1();
    idle(4);
    chk("R1 toggle", {3'b0, q_dec[0]}, 1);

    cur_req = "R2";
    do_clear();
    repeat (7) pulse2();
    idle(4);
    chk("R2 decade", q_dec, 4);
    cur_req = "R3";
    chk("R3 binary", q_bin, 14);
    pulse2(); idle(4);
    chk("R3 wrap", q_bin, 0);
    chk("R2 decade", q_dec, 6);

    cur_req = "R4";
    d = 4'h5; ld_n = 1'b0; idle(2);
    chk("R4 load", q_dec, 5);
    d = 4'hA; idle(1);
    chk("R4 follow", q_dec, 10);
    cur_req = "R10";
    pulse1(); pulse2(); idle(4);
    chk("R10 edges in load", q_dec, 10);
    ld_n = 1'b1; idle(4);
    chk("R10 after load", q_bin, 10);

    cur_req = "R5";
    d = 4'hF; ld_n = 1'b0; clr_n = 1'b0; c1 = 1'b1; idle(2);
    chk("R5 clear wins", q_dec, 0);
    c1 = 1'b0; idle(4); clr_n = 1'b1; ld_n = 1'b1; idle(4);
    chk("R5 edge dropped", q_bin, 0);

    cur_req = "R9";
    d = 4'b1010; ld_n = 1'b0; idle(1); ld_n = 1'b1; idle(1);
    pulse2(); idle(4); chk("R9 5->6", q_dec, 12);
    pulse2(); idle(4); chk("R9 6->7", q_dec, 14);
    pulse2(); idle(4); chk("R9 7->0", q_dec, 0);

    cur_req = "R7";
    do_clear(); link = 1'b1;
    repeat (9) pulse1();
    idle(5);
    chk("R7 bcd nine", q_dec, 9);
    chk("R7 bin nine", q_bin, 9);
    pulse2(); idle(4);
    chk("R7 cnt2 ignored", q_dec, 9);
    pulse1(); idle(5);
    chk("R7 bcd wrap", q_dec, 0);
    repeat (5) pulse1();
    idle(5);
    chk("R7 bin fifteen", q_bin, 15);
    pulse1(); idle(5);
    chk("R7 bin wrap", q_bin, 0);

    cur_req = "R8";
    link = 1'b0; do_clear(); bq = 1'b1; idle(2);
    for (int n = 1; n <= 20; n++) begin
      pulse2(); idle(6);
      chk("R8 biquinary dec", q_dec, (n % 5) * 2 + (n / 5) % 2);
      chk("R8 biquinary bin", q_bin, (n % 8) * 2 + (n / 8) % 2);
    end
    bq = 1'b0; idle(6);

    cur_req = "R10";
    for (int k = 0; k < 5; k++) begin
      pulse1();
      idle(k);
      d = 4'(k * 3 + 1); ld_n = 1'b0; idle(1); ld_n = 1'b1;
      idle(6);
    end
    link = 1'b1;
    for (int k = 0; k < 4; k++) begin
      d = 4'b0001; ld_n = 1'b0; idle(1); ld_n = 1'b1;
      pulse1(); idle(k);
      clr_n = 1'b0; idle(1); clr_n = 1'b1; idle(6);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule